// File: doc/BRIEF.md
# Operand Dispatch Stage with Result Snooping

This block is the dispatch side of a dynamically scheduled core. It holds a small register file in which each entry carries a data value, a busy flag and the index of the station that will produce its next value. It also holds a set of reservation stations, and each station keeps two source operands. Every source operand has a ready bit, a producer index and a data value.

An incoming instruction names a destination register and two source registers. It is written into the lowest-numbered free station. Each source is filled from the register file, or directly from the result bus when the awaited value is on the bus in that same cycle. The destination register is then marked busy under the index of the station.

Stations whose operands are still pending watch the result bus by producer index. A station whose operands are both ready is offered to an execution unit through a valid/ready handshake. The station's index travels with the instruction and comes back as the tag of its result. The execution units sit outside the block and drive the result bus. A combinational read port exposes any register entry for inspection.

Top module: `rs_dispatch`

## Requirements
- R1: After reset, register i holds the value 256+i and is not busy, every station is free, `disp_ready` is 1 and `iss_valid` is 0.
- R2: `disp_ready` is 1 exactly when at least one station is free. An accepted instruction (`disp_valid` and `disp_ready` both high) goes into the free station with the lowest index. A `disp_valid` pulse while `disp_ready` is 0 changes no register and no station.
- R3: At dispatch, a source whose register is not busy is ready at once and takes the register's value.
- R4: At dispatch, a source whose register is busy is ready at once and takes `res_val` when `res_valid` is 1 and `res_tag` equals that register's producer index in the same cycle.
- R5: A busy source that is not bypassed waits for its producer index. It becomes ready with `res_val` on the first cycle in which `res_valid` is 1 with that tag.
- R6: On dispatch, the destination register becomes busy, and its producer index becomes the index of the chosen station. The read port shows this on the next cycle.
- R7: When `res_valid` is 1 and `res_tag` equals a busy register's producer index, that register takes `res_val` and stops being busy.
- R8: When a dispatch names a register as destination in the same cycle that a matching result would clear it, the new reservation wins: the register stays busy under the new index and keeps its old value.
- R9: `iss_valid` is 1 only while some station is loaded with both operands ready. The lowest such index is offered on `iss_tag`, with its operands on `iss_opa`/`iss_opb`. When `iss_ready` is 1, that station becomes issued.
- R10: An issued station becomes free on the cycle after a result carrying its index appears. Its slot counts toward `disp_ready` from that next cycle on.
- R11: A result carrying the index of a station that is loaded but not yet issued leaves that station loaded, and leaves its already-ready operands unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_dst | input | $clog2(NREG) | Destination register |
| disp_srca | input | $clog2(NREG) | First source register |
| disp_srcb | input | $clog2(NREG) | Second source register |
| disp_ready | output | 1 | A station is free |
| iss_valid | output | 1 | A ready station is offered |
| iss_ready | input | 1 | Execution unit accepts the offer |
| iss_tag | output | $clog2(NRS) | Index of the offered station |
| iss_opa | output | DW | First operand of the offered station |
| iss_opb | output | DW | Second operand of the offered station |
| res_valid | input | 1 | Result bus carries a value |
| res_tag | input | $clog2(NRS) | Producer index of the result |
| res_val | input | DW | Result value |
| rd_addr | input | $clog2(NREG) | Read-port register index |
| rd_val | output | DW | Value of the selected register |
| rd_busy | output | 1 | Busy flag of the selected register |
| rd_tag | output | $clog2(NRS) | Producer index of the selected register |

## Verification
Dispatch and result broadcast can land in the same cycle, and two outcomes then depend on getting the order right:
- the operand fetch must pick the bypassed bus value;
- the destination update must let the new reservation override the clearing result.

The bench provokes both cases by driving one dispatch and one broadcast on the same clock edge. It then reuses the broadcasting station's index for a later result with a different value, so an operand that missed the bypass would pick up the wrong data. The scoreboard judges this from the order and contents of the issued operand pairs, and read-port checks confirm the register state.

// File: rtl/rs_dispatch.sv
module rs_dispatch #(
  parameter int NRS  = 4,
  parameter int NREG = 8,
  parameter int DW   = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    disp_valid,
  input  logic [$clog2(NREG)-1:0] disp_dst,
  input  logic [$clog2(NREG)-1:0] disp_srca,
  input  logic [$clog2(NREG)-1:0] disp_srcb,
  output logic                    disp_ready,
  output logic                    iss_valid,
  input  logic                    iss_ready,
  output logic [$clog2(NRS)-1:0]  iss_tag,
  output logic [DW-1:0]           iss_opa,
  output logic [DW-1:0]           iss_opb,
  input  logic                    res_valid,
  input  logic [$clog2(NRS)-1:0]  res_tag,
  input  logic [DW-1:0]           res_val,
  input  logic [$clog2(NREG)-1:0] rd_addr,
  output logic [DW-1:0]           rd_val,
  output logic                    rd_busy,
  output logic [$clog2(NRS)-1:0]  rd_tag
);
  localparam int TW = $clog2(NRS);

  typedef enum logic [1:0] {S_FREE, S_LOAD, S_ISS} st_e;

  logic [DW-1:0]   rval [NREG];
  logic [NREG-1:0] rbusy;
  logic [TW-1:0]   rtag [NREG];

  st_e             st   [NRS];
  logic [NRS-1:0]  a_ok, b_ok;
  logic [TW-1:0]   a_tag [NRS];
  logic [TW-1:0]   b_tag [NRS];
  logic [DW-1:0]   a_val [NRS];
  logic [DW-1:0]   b_val [NRS];

  logic            free_any;
  logic [TW-1:0]   free_sel, iss_sel;
  logic            disp_fire, iss_fire;
  logic            hit_a, hit_b;

  always_comb begin
    free_any = 1'b0;
    free_sel = '0;
    iss_valid = 1'b0;
    iss_sel = '0;
    for (int i = NRS-1; i >= 0; i--) begin
      if (st[i] == S_FREE) begin
        free_any = 1'b1;
        free_sel = TW'(i);
      end
      if (st[i] == S_LOAD && a_ok[i] && b_ok[i]) begin
        iss_valid = 1'b1;
        iss_sel = TW'(i);
      end
    end
  end

  assign disp_ready = free_any;
  assign disp_fire  = disp_valid & free_any;
  assign iss_fire   = iss_valid & iss_ready;
  assign iss_tag    = iss_sel;
  assign iss_opa    = a_val[iss_sel];
  assign iss_opb    = b_val[iss_sel];

  assign hit_a = res_valid & rbusy[disp_srca] & (rtag[disp_srca] == res_tag);
  assign hit_b = res_valid & rbusy[disp_srcb] & (rtag[disp_srcb] == res_tag);

  assign rd_val  = rval[rd_addr];
  assign rd_busy = rbusy[rd_addr];
  assign rd_tag  = rtag[rd_addr];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rst_n) begin
        rval[r]  <= DW'(256 + r);
        rbusy[r] <= 1'b0;
        rtag[r]  <= '0;
      end else if (disp_fire && disp_dst == ($clog2(NREG))'(r)) begin
        rbusy[r] <= 1'b1;
        rtag[r]  <= free_sel;
      end else if (res_valid && rbusy[r] && rtag[r] == res_tag) begin
        rbusy[r] <= 1'b0;
        rval[r]  <= res_val;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NRS; i++) begin
      if (!rst_n) begin
        st[i]    <= S_FREE;
        a_ok[i]  <= 1'b0;
        b_ok[i]  <= 1'b0;
        a_tag[i] <= '0;
        b_tag[i] <= '0;
        a_val[i] <= '0;
        b_val[i] <= '0;
      end else if (disp_fire && free_sel == TW'(i)) begin
        st[i]    <= S_LOAD;
        a_ok[i]  <= hit_a | ~rbusy[disp_srca];
        a_tag[i] <= rtag[disp_srca];
        a_val[i] <= hit_a ? res_val : rval[disp_srca];
        b_ok[i]  <= hit_b | ~rbusy[disp_srcb];
        b_tag[i] <= rtag[disp_srcb];
        b_val[i] <= hit_b ? res_val : rval[disp_srcb];
      end else begin
        if (st[i] == S_ISS && res_valid && res_tag == TW'(i))
          st[i] <= S_FREE;
        else if (iss_fire && iss_sel == TW'(i))
          st[i] <= S_ISS;
        if (!a_ok[i] && res_valid && a_tag[i] == res_tag) begin
          a_ok[i]  <= 1'b1;
          a_val[i] <= res_val;
        end
        if (!b_ok[i] && res_valid && b_tag[i] == res_tag) begin
          b_ok[i]  <= 1'b1;
          b_val[i] <= res_val;
        end
      end
    end
  end

  p_load_lowest_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> st[$past(free_sel)] == S_LOAD);

  p_reserve_dst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |=> rbusy[$past(disp_dst)] && rtag[$past(disp_dst)] == $past(free_sel));

  p_issue_moves_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_fire |=> st[$past(iss_tag)] == S_ISS);

  p_free_on_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && st[res_tag] == S_ISS) |=> st[$past(res_tag)] == S_FREE);

  p_early_result_keeps_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && st[res_tag] == S_LOAD && !(iss_fire && iss_sel == res_tag))
      |=> st[$past(res_tag)] == S_LOAD);
endmodule

// File: tb/tb_rs_dispatch.sv
`timescale 1ns/1ps
module tb_rs_dispatch;
  localparam int NRS = 4, NREG = 8, DW = 16;
  localparam int TW = $clog2(NRS), RW = $clog2(NREG);

  logic clk = 0, rst_n = 0;
  logic disp_valid = 0, iss_ready = 0, res_valid = 0;
  logic [RW-1:0] disp_dst = 0, disp_srca = 0, disp_srcb = 0, rd_addr = 0;
  logic [TW-1:0] res_tag = 0;
  logic [DW-1:0] res_val = 0;
  logic disp_ready, iss_valid, rd_busy;
  logic [TW-1:0] iss_tag, rd_tag;
  logic [DW-1:0] iss_opa, iss_opb, rd_val;

  int total = 0, bad = 0;
  bit done = 0;
  logic [TW+2*DW-1:0] exp_q [$];

  always #2 clk = ~clk;

  rs_dispatch #(.NRS(NRS), .NREG(NREG), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dst(disp_dst),
    .disp_srca(disp_srca), .disp_srcb(disp_srcb), .disp_ready(disp_ready),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .iss_opa(iss_opa), .iss_opb(iss_opb), .res_valid(res_valid),
    .res_tag(res_tag), .res_val(res_val), .rd_addr(rd_addr), .rd_val(rd_val),
    .rd_busy(rd_busy), .rd_tag(rd_tag));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_chk(input string req, input int a, input int v, input int busy);
    rd_addr = RW'(a);
    #1;
    chk(req, {rd_busy, rd_val}, {1'(busy), DW'(v)});
  endtask

  task automatic cyc(input bit dv, input int dst, input int sa, input int sb,
                     input bit rv, input int tag, input int val);
    @(negedge clk);
    disp_valid = dv; disp_dst = RW'(dst); disp_srca = RW'(sa); disp_srcb = RW'(sb);
    res_valid = rv; res_tag = TW'(tag); res_val = DW'(val);
    @(negedge clk);
    disp_valid = 0; res_valid = 0;
  endtask

  task automatic do_issue(input int tag, input int a, input int b);
    exp_q.push_back({TW'(tag), DW'(a), DW'(b)});
    @(negedge clk);
    iss_ready = 1;
    @(negedge clk);
    iss_ready = 0;
  endtask

  // scoreboard monitor (R9 ordering and operand contents)
  initial forever begin
    @(negedge clk);
    #1;
    if (rst_n && iss_valid && iss_ready) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9: unexpected issue actual=%0h expected=none", {iss_tag, iss_opa, iss_opb});
      end else begin
        logic [TW+2*DW-1:0] e;
        e = exp_q.pop_front();
        if ({iss_tag, iss_opa, iss_opb} !== e) begin
          bad++;
          $display("FAIL R9/R3/R4/R5: issue actual=%0h expected=%0h", {iss_tag, iss_opa, iss_opb}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 disp_ready", disp_ready, 1);
    chk("R1 iss_valid", iss_valid, 0);
    for (int r = 0; r < NREG; r++) reg_chk("R1 reg", r, 256 + r, 0);

    // R3/R6: plain dispatch into station 0
    cyc(1, 1, 2, 3, 0, 0, 0);
    rd_addr = 1; #1;
    chk("R6 reg1 tag", {rd_busy, rd_tag}, {1'b1, TW'(0)});
    do_issue(0, 'h102, 'h103);

    // R5: wait on tag 0, then snoop it
    cyc(1, 4, 1, 5, 0, 0, 0);
    #1 chk("R5 waiting not offered", iss_valid, 0);
    cyc(0, 0, 0, 0, 1, 0, 'hAAAA);
    reg_chk("R7 reg1 written", 1, 'hAAAA, 0);
    do_issue(1, 'hAAAA, 'h105);

    // R4: dispatch while producer (station 1) broadcasts; tag 1 reused afterwards
    cyc(1, 6, 4, 4, 1, 1, 'hBEEF);
    reg_chk("R7 reg4 written", 4, 'hBEEF, 0);
    cyc(1, 7, 0, 0, 0, 0, 0);
    do_issue(0, 'hBEEF, 'hBEEF);

    // R8: dispatch to reg6 while its pending result (tag 0) arrives; R4 on srca
    cyc(1, 6, 6, 7, 1, 0, 'h5555);
    rd_addr = 6; #1;
    chk("R8 reg6 new reservation", {rd_busy, rd_tag, rd_val}, {1'b1, TW'(2), DW'('h106)});
    do_issue(1, 'h100, 'h100);
    cyc(0, 0, 0, 0, 1, 1, 'h7777);
    do_issue(2, 'h5555, 'h7777);
    cyc(0, 0, 0, 0, 1, 2, 'h2222);
    reg_chk("R7 reg6 written", 6, 'h2222, 0);

    // R11: early result for a loaded, unissued station
    cyc(1, 3, 3, 2, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 'h9999);
    #1 chk("R11 station still offered", {iss_valid, iss_tag}, {1'b1, TW'(0)});
    do_issue(0, 'h103, 'h102);

    // R2: fill all stations, stalled dispatch ignored
    cyc(1, 0, 5, 5, 0, 0, 0);
    cyc(1, 1, 5, 5, 0, 0, 0);
    cyc(1, 2, 5, 5, 0, 0, 0);
    #1 chk("R2 full stalls", disp_ready, 0);
    cyc(1, 7, 0, 0, 0, 0, 0);
    reg_chk("R2 stalled dispatch ignored", 7, 'h7777, 0);

    // R10: freeing by own result
    cyc(0, 0, 0, 0, 1, 0, 'h4444);
    #1 chk("R10 slot freed", disp_ready, 1);

    // R9: lowest-index priority
    do_issue(1, 'h105, 'h105);
    do_issue(2, 'h105, 'h105);
    do_issue(3, 'h105, 'h105);
    @(negedge clk);
    chk("R9 all expected issues seen", exp_q.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule